// File: doc/BRIEF.md
# Stall-Only Pipeline Hazard Controller

This block decides, every cycle, whether each of the five pipeline registers (fetch, decode, execute, memory, writeback) of an in-order processor without operand forwarding is held or loaded with a bubble. It compares the source register IDs of the instruction in decode against every destination ID still in flight in the execute, memory and writeback registers. On a match it holds fetch and decode and inserts a bubble into execute. This repeats until the producer has left writeback, so a dependent instruction waits three cycles.

The same logic applies the control-flow and exception rules. A return in flight freezes fetch and feeds bubbles into decode. A jump in execute whose condition is false squashes decode and execute. A faulting or halting instruction in memory or writeback blocks further state change: memory receives bubbles, writeback is held, and condition-code updates are suppressed. The block also yields the execute-stage E destination after a failed conditional move has been cancelled. The controller is purely combinational, so each output depends only on the current pipeline-register contents.

Top module: `stall_hazard_ctrl`

## Requirements
- R1: The register ID 0xF means "no register" and never produces a hazard match. A hazard exists when a decode source (A or B) that is not 0xF equals any of six destinations: the adjusted execute E destination, the execute M destination, and the memory-stage and writeback-stage E and M destinations.
- R2: On a hazard with no mispredict, `f_stall` and `d_stall` are 1, `e_bubble` is 1 and `d_bubble` is 0.
- R3: While instruction code 9 (return) sits in the decode, execute or memory stage, `f_stall` is 1. `d_bubble` is also 1 unless decode is held for a hazard.
- R4: A mispredict is execute code 7 (jump) with `e_cond` 0. It sets `d_bubble` and `e_bubble` and overrides any hazard hold, so `d_stall` is 0.
- R5: A memory-stage or writeback-stage status of 2 (halt), 3 (address error) or 4 (invalid instruction) sets `m_bubble`. Status 0 is bubble and status 1 is normal.
- R6: A writeback-stage status of 2, 3 or 4 sets `w_stall`.
- R7: `cc_enable` is 1 only for execute code 6 (ALU operation) when neither the memory-stage nor the writeback-stage status is 2, 3 or 4.
- R8: Execute code 2 (register/conditional move) with `e_cond` 0 drives `e_dst_e_eff` to 0xF. Otherwise `e_dst_e_eff` equals `e_dst_e`.
- R9: No register has stall and bubble both set. `f_bubble`, `e_stall`, `m_stall` and `w_bubble` are always 0.
- R10: With every stage holding a bubble (status 0, all IDs 0xF, code 1), every output is 0 and `e_dst_e_eff` is 0xF.
- R11: A consumer placed directly behind an ALU producer or a load (code 5) of its source gets exactly three execute bubbles. A consumer behind a cancelled conditional move gets none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_icode | input | 4 | Instruction code in decode |
| d_src_a | input | 4 | Decoded source A register ID |
| d_src_b | input | 4 | Decoded source B register ID |
| e_icode | input | 4 | Instruction code in execute |
| e_cond | input | 1 | Condition outcome evaluated in execute |
| e_dst_e | input | 4 | E destination held in the execute register |
| e_dst_m | input | 4 | M destination held in the execute register |
| m_icode | input | 4 | Instruction code in memory stage |
| m_dst_e | input | 4 | E destination in memory-stage register |
| m_dst_m | input | 4 | M destination in memory-stage register |
| m_stat | input | 3 | Status leaving memory stage |
| w_stat | input | 3 | Status in writeback register |
| w_dst_e | input | 4 | E destination in writeback register |
| w_dst_m | input | 4 | M destination in writeback register |
| f_stall | output | 1 | Hold fetch register |
| f_bubble | output | 1 | Bubble into fetch register (always 0) |
| d_stall | output | 1 | Hold decode register |
| d_bubble | output | 1 | Bubble into decode register |
| e_stall | output | 1 | Hold execute register (always 0) |
| e_bubble | output | 1 | Bubble into execute register |
| m_stall | output | 1 | Hold memory register (always 0) |
| m_bubble | output | 1 | Bubble into memory register |
| w_stall | output | 1 | Hold writeback register |
| w_bubble | output | 1 | Bubble into writeback register (always 0) |
| cc_enable | output | 1 | Condition codes may be updated |
| e_dst_e_eff | output | 4 | Execute E destination after move cancellation |

## Verification
Every output is due in the same cycle as the register contents that cause it. The bench therefore applies the pipeline state just after a rising edge and compares the outputs at the following falling edge. The register-level effect of a stall or bubble appears only one cycle later, as new inputs. The bench's behavioural pipeline applies it at the next rising edge, and that is how multi-cycle effects such as the three-bubble wait come about. Those effects are checked by counting bubble and stall cycles over each program, and final-state checks are made after the run.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int REG_W   = 4;
  localparam int CODE_W  = 4;
  localparam int STAT_W  = 3;
  localparam int N_DST   = 6;

  localparam logic [REG_W-1:0]  REG_NONE = 4'hF;

  localparam logic [CODE_W-1:0] IC_NOP   = 4'h1;
  localparam logic [CODE_W-1:0] IC_MOVE  = 4'h2;
  localparam logic [CODE_W-1:0] IC_LOAD  = 4'h5;
  localparam logic [CODE_W-1:0] IC_ALU   = 4'h6;
  localparam logic [CODE_W-1:0] IC_JUMP  = 4'h7;
  localparam logic [CODE_W-1:0] IC_CALL  = 4'h8;
  localparam logic [CODE_W-1:0] IC_RET   = 4'h9;
  localparam logic [CODE_W-1:0] IC_POP   = 4'hB;

  typedef enum logic [STAT_W-1:0] {
    ST_BUB = 3'd0,
    ST_AOK = 3'd1,
    ST_HLT = 3'd2,
    ST_ADR = 3'd3,
    ST_INS = 3'd4
  } stat_e;

  function automatic logic is_fault(input logic [STAT_W-1:0] s);
    return (s == ST_HLT) || (s == ST_ADR) || (s == ST_INS);
  endfunction
endpackage

// File: rtl/hzd_match.sv
module hzd_match
  import hzd_pkg::*;
#(
  parameter int NDST = N_DST
) (
  input  logic [REG_W-1:0]      src,
  input  logic [NDST*REG_W-1:0] dsts,
  output logic                  hit
);
  logic [NDST-1:0] eq;

  genvar gi;
  for (gi = 0; gi < NDST; gi++) begin : g_cmp
    assign eq[gi] = (src != REG_NONE) && (dsts[gi*REG_W +: REG_W] == src);
  end

  assign hit = |eq;

  always_comb begin
    // R1
    none_src_chk: assert (!(hit && (src == REG_NONE)))
      else $error("empty source reported a match");
  end
endmodule

// File: rtl/hzd_data.sv
module hzd_data
  import hzd_pkg::*;
#(
  parameter int NDST = N_DST
) (
  input  logic [REG_W-1:0]      src_a,
  input  logic [REG_W-1:0]      src_b,
  input  logic [NDST*REG_W-1:0] dsts,
  output logic                  raw_hazard
);
  logic hit_a, hit_b;

  hzd_match #(.NDST(NDST)) u_match_a (
    .src  (src_a),
    .dsts (dsts),
    .hit  (hit_a)
  );

  hzd_match #(.NDST(NDST)) u_match_b (
    .src  (src_b),
    .dsts (dsts),
    .hit  (hit_b)
  );

  assign raw_hazard = hit_a | hit_b;

  always_comb begin
    // R1
    both_none_chk: assert (!(raw_hazard && (src_a == REG_NONE) && (src_b == REG_NONE)))
      else $error("hazard with no decode source");
  end
endmodule

// File: rtl/hzd_flow.sv
module hzd_flow
  import hzd_pkg::*;
(
  input  logic [CODE_W-1:0] d_icode,
  input  logic [CODE_W-1:0] e_icode,
  input  logic [CODE_W-1:0] m_icode,
  input  logic              e_cond,
  input  logic [REG_W-1:0]  e_dst_e,
  input  logic [STAT_W-1:0] m_stat,
  input  logic [STAT_W-1:0] w_stat,
  output logic              ret_busy,
  output logic              mispredict,
  output logic              fault_mem,
  output logic              fault_wb,
  output logic              cc_enable,
  output logic [REG_W-1:0]  e_dst_e_eff
);
  assign ret_busy    = (d_icode == IC_RET) || (e_icode == IC_RET) || (m_icode == IC_RET);
  assign mispredict  = (e_icode == IC_JUMP) && !e_cond;
  assign fault_wb    = is_fault(w_stat);
  assign fault_mem   = is_fault(m_stat) || fault_wb;
  assign cc_enable   = (e_icode == IC_ALU) && !fault_mem;
  assign e_dst_e_eff = ((e_icode == IC_MOVE) && !e_cond) ? REG_NONE : e_dst_e;

  always_comb begin
    // R7
    cc_fault_chk: assert (!(cc_enable && fault_wb))
      else $error("condition codes enabled behind a faulting writeback");
    // R8
    move_cancel_chk: assert (!((e_icode == IC_MOVE) && !e_cond && (e_dst_e_eff != REG_NONE)))
      else $error("cancelled move kept its destination");
  end
endmodule

// File: rtl/stall_hazard_ctrl.sv
module stall_hazard_ctrl
  import hzd_pkg::*;
(
  input  logic [3:0] d_icode,
  input  logic [3:0] d_src_a,
  input  logic [3:0] d_src_b,
  input  logic [3:0] e_icode,
  input  logic       e_cond,
  input  logic [3:0] e_dst_e,
  input  logic [3:0] e_dst_m,
  input  logic [3:0] m_icode,
  input  logic [3:0] m_dst_e,
  input  logic [3:0] m_dst_m,
  input  logic [2:0] m_stat,
  input  logic [2:0] w_stat,
  input  logic [3:0] w_dst_e,
  input  logic [3:0] w_dst_m,
  output logic       f_stall,
  output logic       f_bubble,
  output logic       d_stall,
  output logic       d_bubble,
  output logic       e_stall,
  output logic       e_bubble,
  output logic       m_stall,
  output logic       m_bubble,
  output logic       w_stall,
  output logic       w_bubble,
  output logic       cc_enable,
  output logic [3:0] e_dst_e_eff
);
  localparam int DV_W = N_DST * REG_W;

  logic             ret_busy, mispredict, fault_mem, fault_wb;
  logic             raw_hazard, hold_front;
  logic [REG_W-1:0] e_dst_adj;
  logic [DV_W-1:0]  dst_vec;

  hzd_flow u_flow (
    .d_icode     (d_icode),
    .e_icode     (e_icode),
    .m_icode     (m_icode),
    .e_cond      (e_cond),
    .e_dst_e     (e_dst_e),
    .m_stat      (m_stat),
    .w_stat      (w_stat),
    .ret_busy    (ret_busy),
    .mispredict  (mispredict),
    .fault_mem   (fault_mem),
    .fault_wb    (fault_wb),
    .cc_enable   (cc_enable),
    .e_dst_e_eff (e_dst_adj)
  );

  // Order of the destination slots is irrelevant to matching.
  assign dst_vec = {w_dst_m, w_dst_e, m_dst_m, m_dst_e, e_dst_m, e_dst_adj};

  hzd_data #(.NDST(N_DST)) u_data (
    .src_a      (d_src_a),
    .src_b      (d_src_b),
    .dsts       (dst_vec),
    .raw_hazard (raw_hazard)
  );

  // A wrong-path consumer is squashed, never held.
  assign hold_front  = raw_hazard && !mispredict;

  assign f_stall     = hold_front || ret_busy;
  assign f_bubble    = 1'b0;
  assign d_stall     = hold_front;
  assign d_bubble    = mispredict || (ret_busy && !hold_front);
  assign e_stall     = 1'b0;
  assign e_bubble    = mispredict || hold_front;
  assign m_stall     = 1'b0;
  assign m_bubble    = fault_mem;
  assign w_stall     = fault_wb;
  assign w_bubble    = 1'b0;
  assign e_dst_e_eff = e_dst_adj;

  always_comb begin
    // R9
    d_excl_chk: assert (!(d_stall && d_bubble))
      else $error("decode stalled and bubbled together");
    // R2
    hold_bubble_chk: assert (!(d_stall && !(f_stall && e_bubble)))
      else $error("decode hold without fetch hold and execute bubble");
    // R4
    squash_chk: assert (!(mispredict && !(d_bubble && e_bubble && !d_stall)))
      else $error("mispredict not squashed");
    // R6
    wb_hold_chk: assert (!(w_stall && !m_bubble))
      else $error("writeback held while memory still advances");
    // R7
    cc_bubble_chk: assert (!(m_bubble && cc_enable))
      else $error("condition codes enabled during fault");
  end
endmodule

// File: tb/tb_stall_hazard_ctrl.sv
module tb_stall_hazard_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0] ic;
    logic [3:0] sa;
    logic [3:0] sb;
    logic [3:0] de;
    logic [3:0] dm;
    logic [2:0] st;
    logic       cond;
  } slot_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] d_icode, d_src_a, d_src_b, e_icode, e_dst_e, e_dst_m;
  logic [3:0] m_icode, m_dst_e, m_dst_m, w_dst_e, w_dst_m, e_dst_e_eff;
  logic       e_cond;
  logic [2:0] m_stat, w_stat;
  logic f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble;
  logic m_stall, m_bubble, w_stall, w_bubble, cc_enable;

  stall_hazard_ctrl dut (
    .d_icode(d_icode), .d_src_a(d_src_a), .d_src_b(d_src_b),
    .e_icode(e_icode), .e_cond(e_cond), .e_dst_e(e_dst_e), .e_dst_m(e_dst_m),
    .m_icode(m_icode), .m_dst_e(m_dst_e), .m_dst_m(m_dst_m), .m_stat(m_stat),
    .w_stat(w_stat), .w_dst_e(w_dst_e), .w_dst_m(w_dst_m),
    .f_stall(f_stall), .f_bubble(f_bubble), .d_stall(d_stall), .d_bubble(d_bubble),
    .e_stall(e_stall), .e_bubble(e_bubble), .m_stall(m_stall), .m_bubble(m_bubble),
    .w_stall(w_stall), .w_bubble(w_bubble), .cc_enable(cc_enable),
    .e_dst_e_eff(e_dst_e_eff)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  slot_t sd, se, sm, sw;
  slot_t prog [0:7];
  int    plen, pc;
  int    cnt_eb, cnt_db, cnt_fs, cnt_ds, cnt_cc;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic slot_t bub();
    slot_t s;
    s.ic = 4'h1; s.sa = 4'hF; s.sb = 4'hF; s.de = 4'hF; s.dm = 4'hF;
    s.st = 3'd0; s.cond = 1'b1;
    return s;
  endfunction

  function automatic slot_t mk(input logic [3:0] ic, input logic [3:0] sa,
      input logic [3:0] sb, input logic [3:0] de, input logic [3:0] dm,
      input logic [2:0] st, input logic cond);
    slot_t s;
    s.ic = ic; s.sa = sa; s.sb = sb; s.de = de; s.dm = dm; s.st = st; s.cond = cond;
    return s;
  endfunction

  function automatic bit faulty(input logic [2:0] s);
    return s inside {3'd2, 3'd3, 3'd4};
  endfunction

  function automatic logic [3:0] moved_dst(input slot_t s);
    if (s.ic == 4'h2 && !s.cond) return 4'hF;
    return s.de;
  endfunction

  // Expected controls, derived from the requirements
  bit x_fs, x_ds, x_db, x_eb, x_mb, x_ws, x_cc;
  logic [3:0] x_edst;

  task automatic expect_ctrl();
    logic [3:0] busy [6];
    bit raw = 0, mp, rt, hz;
    busy[0] = moved_dst(se); busy[1] = se.dm;
    busy[2] = sm.de; busy[3] = sm.dm; busy[4] = sw.de; busy[5] = sw.dm;
    foreach (busy[k]) begin
      if (busy[k] != 4'hF && (busy[k] == sd.sa || busy[k] == sd.sb)) raw = 1;
    end
    mp = (se.ic == 4'h7) && !se.cond;
    rt = (sd.ic == 4'h9) || (se.ic == 4'h9) || (sm.ic == 4'h9);
    hz = raw && !mp;
    x_fs = hz || rt;
    x_ds = hz;
    x_db = mp || (rt && !hz);
    x_eb = mp || hz;
    x_mb = faulty(sm.st) || faulty(sw.st);
    x_ws = faulty(sw.st);
    x_cc = (se.ic == 4'h6) && !x_mb;
    x_edst = moved_dst(se);
  endtask

  task automatic drive();
    d_icode = sd.ic; d_src_a = sd.sa; d_src_b = sd.sb;
    e_icode = se.ic; e_cond = se.cond; e_dst_e = se.de; e_dst_m = se.dm;
    m_icode = sm.ic; m_dst_e = sm.de; m_dst_m = sm.dm; m_stat = sm.st;
    w_stat = sw.st; w_dst_e = sw.de; w_dst_m = sw.dm;
  endtask

  task automatic compare_all();
    expect_ctrl();
    chk("R3 f_stall",  int'(f_stall),  int'(x_fs));
    chk("R2 d_stall",  int'(d_stall),  int'(x_ds));
    chk("R4 d_bubble", int'(d_bubble), int'(x_db));
    chk("R2 e_bubble", int'(e_bubble), int'(x_eb));
    chk("R5 m_bubble", int'(m_bubble), int'(x_mb));
    chk("R6 w_stall",  int'(w_stall),  int'(x_ws));
    chk("R7 cc_enable", int'(cc_enable), int'(x_cc));
    chk("R8 e_dst_e_eff", int'(e_dst_e_eff), int'(x_edst));
    chk("R9 fixed zero", int'({f_bubble, e_stall, m_stall, w_bubble}), 0);
    chk("R9 d exclusive", int'(d_stall & d_bubble), 0);
  endtask

  task automatic advance();
    slot_t fetched;
    fetched = (pc < plen) ? prog[pc] : mk(4'h1, 4'hF, 4'hF, 4'hF, 4'hF, 3'd1, 1'b1);
    if (!x_ws) begin sw = sm; sw.de = sm.de; end
    if (x_mb) sm = bub();
    else begin sm = se; sm.de = moved_dst(se); end
    if (x_eb) se = bub(); else se = sd;
    if (!x_ds) begin
      if (x_db) sd = bub(); else sd = fetched;
    end
    if (!x_fs) pc++;
  endtask

  task automatic run(input int ncyc);
    sd = bub(); se = bub(); sm = bub(); sw = bub(); pc = 0;
    cnt_eb = 0; cnt_db = 0; cnt_fs = 0; cnt_ds = 0; cnt_cc = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk);
      #1 drive();
      @(negedge clk);
      compare_all();
      cnt_eb += int'(e_bubble); cnt_db += int'(d_bubble);
      cnt_fs += int'(f_stall);  cnt_ds += int'(d_stall);
      cnt_cc += int'(cc_enable);
      advance();
    end
  endtask

  initial begin
    sd = bub(); se = bub(); sm = bub(); sw = bub();
    drive();
    // R10 idle pipeline: everything quiet
    @(negedge clk);
    chk("R10 idle stalls", int'({f_stall, d_stall, w_stall}), 0);
    chk("R10 idle bubbles", int'({d_bubble, e_bubble, m_bubble}), 0);
    chk("R10 idle cc", int'(cc_enable), 0);
    chk("R10 idle dst", int'(e_dst_e_eff), 15);

    // R11 ALU producer then consumer
    prog[0] = mk(4'h6, 4'h0, 4'h1, 4'h1, 4'hF, 3'd1, 1'b1);
    prog[1] = mk(4'h6, 4'h1, 4'h2, 4'h2, 4'hF, 3'd1, 1'b1);
    plen = 2; run(10);
    chk("R11 alu pair e_bubble count", cnt_eb, 3);
    chk("R2 alu pair d_stall count", cnt_ds, 3);

    // R11 load then use
    prog[0] = mk(4'h5, 4'hF, 4'h4, 4'hF, 4'h3, 3'd1, 1'b1);
    prog[1] = mk(4'h6, 4'h3, 4'h3, 4'h3, 4'hF, 3'd1, 1'b1);
    plen = 2; run(10);
    chk("R11 load use e_bubble count", cnt_eb, 3);

    // R3 return passes through
    prog[0] = mk(4'h9, 4'h4, 4'h4, 4'h4, 4'hF, 3'd1, 1'b1);
    plen = 1; run(10);
    chk("R3 ret f_stall count", cnt_fs, 3);
    chk("R3 ret d_bubble count", cnt_db, 3);
    chk("R3 ret e_bubble count", cnt_eb, 0);

    // R4 mispredicted jump
    prog[0] = mk(4'h7, 4'hF, 4'hF, 4'hF, 4'hF, 3'd1, 1'b0);
    plen = 1; run(8);
    chk("R4 mispredict d_bubble count", cnt_db, 1);
    chk("R4 mispredict e_bubble count", cnt_eb, 1);

    // R4 mispredict while wrong-path consumer would hazard
    prog[0] = mk(4'h6, 4'h0, 4'h0, 4'h5, 4'hF, 3'd1, 1'b1);
    prog[1] = mk(4'h7, 4'hF, 4'hF, 4'hF, 4'hF, 3'd1, 1'b0);
    prog[2] = mk(4'h6, 4'h5, 4'h5, 4'h6, 4'hF, 3'd1, 1'b1);
    plen = 3; run(10);
    chk("R4 squash d_stall count", cnt_ds, 0);
    chk("R4 squash e_bubble count", cnt_eb, 1);

    // R5 R6 R7 fault reaches memory then writeback
    prog[0] = mk(4'h3, 4'hF, 4'hF, 4'h7, 4'hF, 3'd3, 1'b1);
    prog[1] = mk(4'h6, 4'h0, 4'h0, 4'h8, 4'hF, 3'd1, 1'b1);
    prog[2] = mk(4'h6, 4'h0, 4'h0, 4'h9, 4'hF, 3'd1, 1'b1);
    plen = 3; run(8);
    chk("R5 fault m_bubble held", int'(m_bubble), 1);
    chk("R6 fault w_stall held", int'(w_stall), 1);
    chk("R7 fault cc_enable count", cnt_cc, 0);

    // R8 R11 cancelled move does not block its reader
    prog[0] = mk(4'h2, 4'h1, 4'hF, 4'h6, 4'hF, 3'd1, 1'b0);
    prog[1] = mk(4'h6, 4'h6, 4'h6, 4'h6, 4'hF, 3'd1, 1'b1);
    plen = 2; run(10);
    chk("R8 cancelled move e_bubble count", cnt_eb, 0);

    // R8 taken move does block
    prog[0] = mk(4'h2, 4'h1, 4'hF, 4'h6, 4'hF, 3'd1, 1'b1);
    plen = 2; run(10);
    chk("R8 taken move e_bubble count", cnt_eb, 3);

    // R1 source 0xF against destination 0xF never matches
    prog[0] = mk(4'h6, 4'hF, 4'hF, 4'hF, 4'hF, 3'd1, 1'b1);
    prog[1] = mk(4'h6, 4'hF, 4'hF, 4'hF, 4'hF, 3'd1, 1'b1);
    plen = 2; run(8);
    chk("R1 none id e_bubble count", cnt_eb, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule